// File: doc/BRIEF.md
# Triggered Burst Clock Generator

This block produces short trains of serial clock pulses on one of several clock output lines. Each train starts when a trigger input rises. A host drives it through a small command port that takes a function code and a parameter. With that port the host picks the active clock line, turns its output driver on or off, and moves the block into or out of a continuous triggered-burst mode. Pulse rates come from dividing the system clock.

The trigger input does two jobs. Its rising edge starts a burst. Its level, sampled a fixed two system cycles after the detected edge, picks the rate: high gives the fast rate and low gives the slow one. Burst mode re-arms after every train and never ends by itself. To leave it, the host writes the ready code, and the next trigger edge then fires one last train at the fast rate before the block goes idle.

The command port is a valid/ready channel. A transfer takes place on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low the host must hold back non-zero codes. A non-zero code presented in that state is not taken, so the host keeps `cmd_valid` asserted until it sees `cmd_ready`. The only exception is the ready code 0, which is taken whenever `cmd_valid` is high. `cmd_reg` reflects the command register at all times.

Top module: `burst_clk_gen`

## Requirements
- R1: After reset, `cmd_ready` is 1, `cmd_reg` is 0, `sclk_oe` is all zeros, `sclk_o` is all zeros, and line 0 is the selected line.
- R2: A non-zero code is accepted only on an edge with `cmd_valid` and `cmd_ready` both high. On the next cycle `cmd_reg` holds the code and `cmd_ready` is low. For codes 1, 2, 3, 5, 6 and 7, one cycle after that `cmd_reg` returns to 0 and `cmd_ready` returns to 1.
- R3: Code 1 (initialize) takes `cmd_param` = k (0 to 3) and selects clock line k. From then on only bit k of `sclk_o` and `sclk_oe` can be high.
- R4: Code 2 (enable) sets `sclk_oe` to the one-hot mask of the selected line. Code 3 (disable) sets `sclk_oe` to all zeros, so the line is high impedance.
- R5: Codes 5, 6 and 7 change neither the selected line nor the output enable.
- R6: Code 4 enters burst mode. `cmd_reg` then stays at 4 and `cmd_ready` stays low. Non-zero codes written during burst mode have no effect.
- R7: The trigger passes through a two-flop synchronizer. In burst mode, each rising edge produces exactly 8 pulses on the selected line. Between bursts the line rests low.
- R8: The synchronized trigger level two cycles after the detected edge selects the rate. High selects the fast rate: system clock divided by 4, each pulse high 2 cycles and low 2 cycles. Low selects the slow rate: divided by 16, high 8 cycles and low 8 cycles.
- R9: Trigger edges that arrive while a burst is being timed or emitted are ignored and add no pulses.
- R10: Writing code 0 clears `cmd_reg` at once, but `cmd_ready` stays low. The next trigger edge fires one dummy 8-pulse burst at the fast rate whatever the trigger level. After that burst `cmd_ready` returns to 1, and later trigger edges produce no pulses.
- R11: After each ordinary burst the block re-arms, so the next trigger edge produces another 8-pulse burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_ready | output | 1 | Block idle and able to take a non-zero command |
| cmd_code | input | 3 | Function code (0 ready, 1 init, 2 enable, 3 disable, 4 burst mode) |
| cmd_param | input | 2 | Clock line index for the init code |
| cmd_reg | output | 3 | Current content of the command register |
| trig_in | input | 1 | Asynchronous trigger and rate-select input |
| sclk_o | output | 4 | Clock output value per line |
| sclk_oe | output | 4 | Output drive enable per line (0 = high impedance) |

## Verification
The bench goes after the shared trigger and rate line. Short trigger pulses must give slow trains and long ones fast trains. A design that sampled the level at the edge itself, or at the wrong delay, would return the wrong rate for one of the two kinds of pulse. The exit sequence is driven with a short (slow-level) pulse, so a design that did not force the dummy burst to the fast rate shows a high width of 8 where 2 is expected. A design that raised ready as soon as the host wrote zero would show `cmd_ready` too early. A second trigger is fired in the middle of a slow burst, and the run must still count exactly eight rising edges. Commands written during burst mode, and unused codes, are checked against the output-enable mask so that a design that acted on them is exposed.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam logic [2:0] FN_IDLE  = 3'd0;
  localparam logic [2:0] FN_INIT  = 3'd1;
  localparam logic [2:0] FN_ON    = 3'd2;
  localparam logic [2:0] FN_OFF   = 3'd3;
  localparam logic [2:0] FN_BURST = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_ARMED,
    ST_SETTLE,
    ST_BURST
  } ctrl_state_e;
endpackage

// File: rtl/bcg_trig_sync.sv
module bcg_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bcg_burst_timer.sv
module bcg_burst_timer #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 16,
  parameter int PULSES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  output logic level,
  output logic done
);
  localparam int HALF_F = DIV_FAST / 2;
  localparam int HALF_S = DIV_SLOW / 2;
  localparam int HMAX   = (HALF_S > HALF_F) ? HALF_S : HALF_F;
  localparam int HW     = $clog2(HMAX + 1);
  localparam int PHASES = 2 * PULSES;
  localparam int PW     = $clog2(PHASES);

  logic [HW-1:0] hc_q;
  logic [PW-1:0] ph_q;
  logic          fast_q;
  logic          act_q;
  logic          done_q;
  logic [HW-1:0] half_last;

  assign half_last = fast_q ? HW'(HALF_F - 1) : HW'(HALF_S - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      ph_q   <= '0;
      fast_q <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        fast_q <= fast;
        hc_q   <= '0;
        ph_q   <= '0;
      end else if (act_q) begin
        if (hc_q == half_last) begin
          hc_q <= '0;
          if (ph_q == PW'(PHASES - 1)) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end else begin
          hc_q <= hc_q + 1'b1;
        end
      end
    end
  end

  assign level = act_q & ~ph_q[0];
  assign done  = done_q;
endmodule

// File: rtl/bcg_cmd_ctrl.sv
module bcg_cmd_ctrl
  import burst_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int SETTLE = 2,
  localparam int PRW   = $clog2(LINES),
  localparam int SW    = $clog2(SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [PRW-1:0]   cmd_param,
  output logic             cmd_ready,
  output logic [2:0]       cmd_reg,
  input  logic             trig_level,
  input  logic             trig_rise,
  input  logic             burst_done,
  output logic             burst_start,
  output logic             burst_fast,
  output logic [LINES-1:0] sel_mask,
  output logic             drive_en
);
  ctrl_state_e      st_q;
  logic [2:0]       fn_q;
  logic [PRW-1:0]   par_q;
  logic [LINES-1:0] mask_q;
  logic             oe_q;
  logic [SW-1:0]    set_q;
  logic             dummy_q;
  logic             accept;
  logic             leave;

  assign cmd_ready   = (st_q == ST_IDLE);
  assign accept      = cmd_valid && cmd_ready && (cmd_code != FN_IDLE);
  assign leave       = cmd_valid && (cmd_code == FN_IDLE);
  assign burst_start = (st_q == ST_SETTLE) && (set_q == SW'(SETTLE - 1));
  assign burst_fast  = trig_level | (fn_q == FN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fn_q    <= FN_IDLE;
      par_q   <= '0;
      mask_q  <= LINES'(1);
      oe_q    <= 1'b0;
      set_q   <= '0;
      dummy_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            fn_q  <= cmd_code;
            par_q <= cmd_param;
            st_q  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          st_q <= ST_IDLE;
          fn_q <= FN_IDLE;
          case (fn_q)
            FN_INIT:  mask_q <= LINES'(1) << par_q;
            FN_ON:    oe_q   <= 1'b1;
            FN_OFF:   oe_q   <= 1'b0;
            FN_BURST: begin
              st_q <= ST_ARMED;
              fn_q <= FN_BURST;
            end
            default: ;
          endcase
        end
        ST_ARMED: begin
          if (trig_rise) begin
            st_q  <= ST_SETTLE;
            set_q <= '0;
          end
        end
        ST_SETTLE: begin
          if (burst_start) begin
            st_q    <= ST_BURST;
            dummy_q <= (fn_q == FN_IDLE);
          end else begin
            set_q <= set_q + 1'b1;
          end
        end
        ST_BURST: begin
          if (burst_done) st_q <= dummy_q ? ST_IDLE : ST_ARMED;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (leave) fn_q <= FN_IDLE;
    end
  end

  assign cmd_reg  = fn_q;
  assign sel_mask = mask_q;
  assign drive_en = oe_q;
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen #(
  parameter int LINES    = 4,
  parameter int PULSES   = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 16,
  parameter int SETTLE   = 2,
  parameter int SYNC     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_code,
  input  logic [$clog2(LINES)-1:0] cmd_param,
  output logic [2:0]               cmd_reg,
  input  logic                     trig_in,
  output logic [LINES-1:0]         sclk_o,
  output logic [LINES-1:0]         sclk_oe
);
  logic             trig_level;
  logic             trig_rise;
  logic             burst_start;
  logic             burst_fast;
  logic             burst_done;
  logic             burst_level;
  logic [LINES-1:0] sel_mask;
  logic             drive_en;

  bcg_trig_sync #(.STAGES(SYNC)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .level   (trig_level),
    .rise    (trig_rise)
  );

  bcg_cmd_ctrl #(.LINES(LINES), .SETTLE(SETTLE)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_param   (cmd_param),
    .cmd_ready   (cmd_ready),
    .cmd_reg     (cmd_reg),
    .trig_level  (trig_level),
    .trig_rise   (trig_rise),
    .burst_done  (burst_done),
    .burst_start (burst_start),
    .burst_fast  (burst_fast),
    .sel_mask    (sel_mask),
    .drive_en    (drive_en)
  );

  bcg_burst_timer #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .PULSES   (PULSES)
  ) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (burst_start),
    .fast  (burst_fast),
    .level (burst_level),
    .done  (burst_done)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign sclk_o[i]  = sel_mask[i] & burst_level;
    assign sclk_oe[i] = sel_mask[i] & drive_en;
  end
endmodule

// File: rtl/burst_clk_gen_chk.sv
module burst_clk_gen_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_code,
  input logic [2:0]       cmd_reg,
  input logic [LINES-1:0] sclk_o,
  input logic [LINES-1:0] sclk_oe
);
  // R3
  oe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sclk_oe));

  // R3
  sclk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sclk_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !(cmd_valid && cmd_code != 3'd0)) |=> cmd_ready);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_code != 3'd0) |=> (!cmd_ready && cmd_reg == $past(cmd_code)));

  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (cmd_reg == 3'd0 && sclk_o == '0));

  // R4
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid && cmd_ready && cmd_code == 3'd3, 2) &&
     !$past(cmd_valid && cmd_code == 3'd0, 1)) |-> (sclk_oe == '0));
endmodule

bind burst_clk_gen burst_clk_gen_chk #(.LINES(LINES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_reg   (cmd_reg),
  .sclk_o    (sclk_o),
  .sclk_oe   (sclk_oe)
);

// File: tb/burst_clk_gen_tb.sv
module burst_clk_gen_tb_top;
  localparam int TB_DIV_FAST = 4;
  localparam int TB_DIV_SLOW = 16;
  localparam int TB_PULSES   = 8;
  localparam int WIN         = 220;
  localparam int WD_CYCLES   = 150000;
  // vector: {line[1:0], fast}
  localparam logic [2:0] VEC [0:3] = '{3'b001, 3'b010, 3'b101, 3'b110};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_code = 3'd0;
  logic [1:0] cmd_param = 2'd0;
  logic [2:0] cmd_reg;
  logic       trig_in = 1'b0;
  logic [3:0] sclk_o;
  logic [3:0] sclk_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  burst_clk_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_code  (cmd_code),
    .cmd_param (cmd_param),
    .cmd_reg   (cmd_reg),
    .trig_in   (trig_in),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] code, input logic [1:0] par);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_param = par;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400; i++) begin
      if (cmd_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic trig_pulse(input int len);
    @(negedge clk);
    trig_in = 1'b1;
    repeat (len) @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic measure(input int line, output int rises, output int wmin,
                         output int wmax, output int stray);
    logic prev;
    int   run;
    prev = 1'b0; run = 0; rises = 0; wmin = 1000; wmax = 0; stray = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if ((sclk_o & ~(4'b0001 << line)) != 4'b0000) stray++;
      if (sclk_o[line]) begin
        if (!prev) rises++;
        run++;
      end else if (run > 0) begin
        if (run < wmin) wmin = run;
        if (run > wmax) wmax = run;
        run = 0;
      end
      prev = sclk_o[line];
    end
    if (run > 0) begin
      if (run < wmin) wmin = run;
      if (run > wmax) wmax = run;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rises, wmin, wmax, stray, wexp;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    chk(cmd_reg == 3'd0, "R1 cmd_reg", int'(cmd_reg), 0);
    chk(sclk_oe == 4'b0000 && sclk_o == 4'b0000, "R1 outputs", int'(sclk_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after release", int'(cmd_ready), 1);
    host_write(3'd2, 2'd0);
    wait_ready();
    chk(sclk_oe == 4'b0001, "R1 default line 0", int'(sclk_oe), 1);

    for (int v = 0; v < 4; v++) begin
      int  line;
      bit  fast;
      line = int'(VEC[v][2:1]);
      fast = VEC[v][0];
      wexp = fast ? TB_DIV_FAST / 2 : TB_DIV_SLOW / 2;
      host_write(3'd1, VEC[v][2:1]);
      chk(cmd_reg == 3'd1 && !cmd_ready, "R2 busy after accept", int'(cmd_reg), 1);
      @(negedge clk);
      chk(cmd_ready && cmd_reg == 3'd0, "R2 ready after init", int'(cmd_reg), 0);
      host_write(3'd2, 2'd0);
      wait_ready();
      chk(sclk_oe == (4'b0001 << line), "R3 R4 enable mask", int'(sclk_oe), 1 << line);
      host_write(3'd4, 2'd0);
      @(negedge clk);
      chk(cmd_reg == 3'd4 && !cmd_ready, "R6 in burst mode", int'(cmd_reg), 4);
      fork
        trig_pulse(fast ? 8 : 2);
        measure(line, rises, wmin, wmax, stray);
      join
      chk(rises == TB_PULSES, "R7 pulse count", rises, TB_PULSES);
      chk(wmin == wexp && wmax == wexp, "R8 high width", wmax, wexp);
      chk(stray == 0, "R3 other lines quiet", stray, 0);
      // R11 re-arm
      fork
        trig_pulse(fast ? 8 : 2);
        measure(line, rises, wmin, wmax, stray);
      join
      chk(rises == TB_PULSES, "R11 second burst", rises, TB_PULSES);
      chk(wmax == wexp, "R11 R8 second width", wmax, wexp);
      // R10 exit with dummy burst
      host_write(3'd0, 2'd0);
      chk(cmd_reg == 3'd0 && !cmd_ready, "R10 ready held low", int'(cmd_ready), 0);
      fork
        trig_pulse(2);
        measure(line, rises, wmin, wmax, stray);
      join
      chk(rises == TB_PULSES, "R10 dummy count", rises, TB_PULSES);
      chk(wmin == TB_DIV_FAST / 2 && wmax == TB_DIV_FAST / 2, "R10 dummy fast", wmax, TB_DIV_FAST / 2);
      chk(cmd_ready == 1'b1, "R10 ready after dummy", int'(cmd_ready), 1);
    end

    // R5 unused code leaves line and enable alone (line 3 enabled)
    host_write(3'd5, 2'd1);
    wait_ready();
    chk(sclk_oe == 4'b1000 && cmd_reg == 3'd0, "R5 code 5 no effect", int'(sclk_oe), 8);
    host_write(3'd7, 2'd0);
    wait_ready();
    chk(sclk_oe == 4'b1000, "R5 code 7 no effect", int'(sclk_oe), 8);

    // R4 disable
    host_write(3'd3, 2'd0);
    chk(cmd_reg == 3'd3, "R2 code shown", int'(cmd_reg), 3);
    wait_ready();
    chk(sclk_oe == 4'b0000, "R4 tristate", int'(sclk_oe), 0);

    // R6 writes during burst mode ignored
    host_write(3'd4, 2'd0);
    host_write(3'd2, 2'd0);
    repeat (4) @(negedge clk);
    chk(sclk_oe == 4'b0000 && cmd_reg == 3'd4, "R6 enable ignored", int'(sclk_oe), 0);
    host_write(3'd1, 2'd0);
    repeat (4) @(negedge clk);
    chk(cmd_reg == 3'd4, "R6 init ignored", int'(cmd_reg), 4);

    // R9 retrigger in the middle of a slow burst
    fork
      trig_pulse(2);
      begin
        repeat (40) @(negedge clk);
        trig_pulse(2);
      end
      measure(3, rises, wmin, wmax, stray);
    join
    chk(rises == TB_PULSES, "R9 mid-burst edge ignored", rises, TB_PULSES);
    chk(wmax == TB_DIV_SLOW / 2, "R9 R8 slow width", wmax, TB_DIV_SLOW / 2);

    host_write(3'd0, 2'd0);
    fork
      trig_pulse(2);
      measure(3, rises, wmin, wmax, stray);
    join
    chk(rises == TB_PULSES && cmd_ready, "R10 exit from tristated mode", rises, TB_PULSES);

    // R10 triggers after exit produce nothing
    fork
      trig_pulse(8);
      measure(3, rises, wmin, wmax, stray);
    join
    chk(rises == 0, "R10 idle trigger silent", rises, 0);
    chk(cmd_ready == 1'b1 && cmd_reg == 3'd0, "R10 still idle", int'(cmd_reg), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule